// File: doc/BRIEF.md
# Deblocking Edge Filter Datapath

This block corrects the two pixels that sit on either side of one block boundary in an 8-bit video reference frame. An edge is eight lines long. For each line the caller supplies four neighbouring pixels taken straight across the boundary: x0 and x1 on the near side, x2 and x3 on the far side. The block computes a rounded, weighted difference across the boundary. It passes that difference through a tent-shaped limiter set by a per-frame strength L, then adds the result to x1, subtracts it from x2 and clamps both results. The outer pixels x0 and x3 are only read. They never come back out.

For an edge between columns, the caller takes the four pixels along a row. For an edge between rows, it takes them down a column. The direction bit travels with each line, so a caller that writes results back to memory knows which way to place them. Lines enter and leave on valid/ready streams. An input line transfers on a clock edge where `in_valid` and `in_ready` are both high. An output line transfers on a clock edge where `out_valid` and `out_ready` are both high. When `out_ready` is low while a result is waiting, the whole pipeline freezes: the waiting result and its tag stay unchanged, and `in_ready` drops in the same cycle. The strength register is loaded once per frame and then applies to every edge that follows.

Top module: `deblock_edge_filter`

## Requirements
- R1: For each line the raw value is R = floor((x0 - x3 + 3*(x2 - x1) + 4) / 8), computed without overflow for any 8-bit inputs. R ranges from -127 to 128.
- R2: The correction is lf = sign(R) * min(|R|, max(2L - |R|, 0)). It equals R when |R| <= L, and it is zero when |R| >= 2L.
- R3: The outputs are x1 + lf and x2 - lf, each clamped to the range 0..255.
- R4: A pulse on `lim_load` stores 2*`lim_val`, and that value applies to every following line until the next load. After reset the stored value is zero, so every line passes through unchanged.
- R5: A line that transfers in on a clock edge is held in the output registers immediately after the third clock edge, counting the accepting edge as the first. The block accepts one line per cycle when it is not stalled.
- R6: While `out_valid` is high and `out_ready` is low, `in_ready` is low, and `out_pair` and `out_dir` hold their values.
- R7: `out_edge_end` is high together with every eighth output line that transfers, counted from reset. Only transfers advance the count.
- R8: `in_dir` travels with its line and appears unchanged on `out_dir`. 0 means the pixels run along a row and 1 means they run down a column.
- R9: Packing: `in_quad` holds x0 in bits 7:0, x1 in 15:8, x2 in 23:16 and x3 in 31:24. `out_pair` holds the new x1 in bits 7:0 and the new x2 in 15:8.
- R10: During and right after reset, `out_valid` and `out_edge_end` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lim_load | input | 1 | Load the filter strength |
| lim_val | input | 7 | Filter strength L |
| in_valid | input | 1 | Input line valid |
| in_ready | output | 1 | Block can take a line |
| in_quad | input | 32 | Four pixels across the edge |
| in_dir | input | 1 | Edge direction tag |
| out_valid | output | 1 | Corrected pair valid |
| out_ready | input | 1 | Consumer takes the pair |
| out_pair | output | 16 | Corrected x1 and x2 |
| out_dir | output | 1 | Direction tag of the output line |
| out_edge_end | output | 1 | Marks the eighth line of an edge |

## Verification
Back-pressure and intake can collide. A result can be waiting with `out_ready` low while a new line is already offered on the input, and at the same point the three in-flight lines must stay frozen. The bench fills the pipeline with `out_ready` held low and keeps a fourth line offered. Over several cycles it checks that `in_ready` stays low and that the waiting pair stays unchanged. It then releases `out_ready` and checks that every line comes out exactly once, in order, with the value worked out for it. The other collision is the edge-end marker on an eighth output that transfers in the same cycle as a new line is accepted. This happens during back-to-back streaming, and the bench judges it from its own count of output transfers.

// File: rtl/dbf_pkg.sv
package dbf_pkg;

  typedef enum logic {
    EDGE_ROW = 1'b0,
    EDGE_COL = 1'b1
  } edge_dir_e;

  // magnitude of a sign-extended value, used by the checks only
  function automatic logic [15:0] mag16(input logic signed [15:0] v);
    return v[15] ? 16'(-v) : 16'(v);
  endfunction

endpackage

// File: rtl/dbf_raw.sv
// Stage 1 arithmetic: rounded weighted difference across the edge (R1).
module dbf_raw #(
  parameter int PIX_W = 8
) (
  input  logic [PIX_W-1:0]        x0,
  input  logic [PIX_W-1:0]        x1,
  input  logic [PIX_W-1:0]        x2,
  input  logic [PIX_W-1:0]        x3,
  output logic signed [PIX_W:0]   raw
);
  // four guard bits: |x0-x3| + 3|x2-x1| + 4 reaches 4*(2^PIX_W) exactly
  localparam int SW = PIX_W + 4;
  localparam logic signed [SW-1:0] RND = SW'(4);

  logic signed [SW-1:0] e0, e1, e2, e3, d_mid, d_out, acc;
  logic unused_lsb;

  assign e0    = $signed({{(SW-PIX_W){1'b0}}, x0});
  assign e1    = $signed({{(SW-PIX_W){1'b0}}, x1});
  assign e2    = $signed({{(SW-PIX_W){1'b0}}, x2});
  assign e3    = $signed({{(SW-PIX_W){1'b0}}, x3});
  assign d_mid = e2 - e1;
  assign d_out = e0 - e3;
  assign acc   = d_out + d_mid + (d_mid <<< 1) + RND;
  // dropping three LSBs of a two's-complement value is a floor division by 8
  assign raw        = acc[SW-1:3];
  assign unused_lsb = ^acc[2:0];
endmodule

// File: rtl/dbf_tent.sv
// Stage 2 arithmetic: tent limiter controlled by the stored 2L (R2).
module dbf_tent #(
  parameter int PIX_W = 8
) (
  input  logic signed [PIX_W:0]   raw,
  input  logic [PIX_W-1:0]        twol,
  output logic signed [PIX_W:0]   lf
);
  localparam logic [PIX_W:0] ONE = {{PIX_W{1'b0}}, 1'b1};

  logic           neg;
  logic [PIX_W:0] rv, absr, thr, room, mag;

  assign neg  = raw[PIX_W];
  assign rv   = raw;
  assign absr = neg ? (~rv + ONE) : rv;
  assign thr  = {1'b0, twol};
  assign room = (thr > absr) ? (thr - absr) : '0;
  assign mag  = (absr < room) ? absr : room;
  assign lf   = neg ? $signed(~mag + ONE) : $signed(mag);
endmodule

// File: rtl/dbf_apply.sv
// Stage 3 arithmetic: apply the correction and clamp to pixel range (R3).
module dbf_apply #(
  parameter int PIX_W = 8
) (
  input  logic [PIX_W-1:0]        x1,
  input  logic [PIX_W-1:0]        x2,
  input  logic signed [PIX_W:0]   lf,
  output logic [PIX_W-1:0]        n1,
  output logic [PIX_W-1:0]        n2
);
  localparam int W = PIX_W + 2;

  logic signed [W-1:0] lfx, s1, s2;

  function automatic logic [PIX_W-1:0] clip(input logic signed [W-1:0] v);
    if (v[W-1])      return '0;
    else if (v[W-2]) return '1;
    else             return v[PIX_W-1:0];
  endfunction

  assign lfx = {lf[PIX_W], lf};
  assign s1  = $signed({2'b00, x1}) + lfx;
  assign s2  = $signed({2'b00, x2}) - lfx;
  assign n1  = clip(s1);
  assign n2  = clip(s2);
endmodule

// File: rtl/deblock_edge_filter.sv
module deblock_edge_filter
  import dbf_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int LINES = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 lim_load,
  input  logic [PIX_W-2:0]     lim_val,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [4*PIX_W-1:0]   in_quad,
  input  logic                 in_dir,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [2*PIX_W-1:0]   out_pair,
  output logic                 out_dir,
  output logic                 out_edge_end
);
  localparam int CNT_W = (LINES > 1) ? $clog2(LINES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LINES - 1);

  // global advance: the pipeline moves when the output slot is free or draining
  logic adv;
  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  // strength register, holds 2L (R4)
  logic [PIX_W-1:0] twol;
  always_ff @(posedge clk) begin
    if (!rst_n)        twol <= '0;
    else if (lim_load) twol <= {lim_val, 1'b0};
  end

  // unpack per R9
  logic [PIX_W-1:0] px [4];
  for (genvar g = 0; g < 4; g++) begin : g_unpack
    assign px[g] = in_quad[g*PIX_W +: PIX_W];
  end

  // ---------------- stage 1: raw difference ----------------
  logic signed [PIX_W:0] raw_c;
  dbf_raw #(.PIX_W(PIX_W)) u_raw (
    .x0(px[0]), .x1(px[1]), .x2(px[2]), .x3(px[3]), .raw(raw_c)
  );

  logic                  s1_v;
  logic signed [PIX_W:0] s1_raw;
  logic [PIX_W-1:0]      s1_x1, s1_x2;
  edge_dir_e             s1_dir;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v <= 1'b0; s1_raw <= '0; s1_x1 <= '0; s1_x2 <= '0; s1_dir <= EDGE_ROW;
    end else if (adv) begin
      s1_v   <= in_valid;
      s1_raw <= raw_c;
      s1_x1  <= px[1];
      s1_x2  <= px[2];
      s1_dir <= edge_dir_e'(in_dir);
    end
  end

  // ---------------- stage 2: tent limiter ----------------
  logic signed [PIX_W:0] lf_c;
  dbf_tent #(.PIX_W(PIX_W)) u_tent (.raw(s1_raw), .twol(twol), .lf(lf_c));

  logic                  s2_v;
  logic signed [PIX_W:0] s2_lf;
  logic [PIX_W-1:0]      s2_x1, s2_x2;
  edge_dir_e             s2_dir;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s2_v <= 1'b0; s2_lf <= '0; s2_x1 <= '0; s2_x2 <= '0; s2_dir <= EDGE_ROW;
    end else if (adv) begin
      s2_v   <= s1_v;
      s2_lf  <= lf_c;
      s2_x1  <= s1_x1;
      s2_x2  <= s1_x2;
      s2_dir <= s1_dir;
    end
  end

  // ---------------- stage 3: apply and clamp ----------------
  logic [PIX_W-1:0] n1_c, n2_c;
  dbf_apply #(.PIX_W(PIX_W)) u_apply (
    .x1(s2_x1), .x2(s2_x2), .lf(s2_lf), .n1(n1_c), .n2(n2_c)
  );

  edge_dir_e out_dir_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0; out_pair <= '0; out_dir_q <= EDGE_ROW;
    end else if (adv) begin
      out_valid <= s2_v;
      out_pair  <= {n2_c, n1_c};
      out_dir_q <= s2_dir;
    end
  end
  assign out_dir = out_dir_q;

  // edge line counter, advanced by output transfers only (R7)
  logic [CNT_W-1:0] line_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n) line_cnt <= '0;
    else if (out_valid && out_ready)
      line_cnt <= (line_cnt == LAST) ? '0 : line_cnt + 1'b1;
  end
  assign out_edge_end = out_valid && (line_cnt == LAST);

  // ---------------- assertions ----------------
  // R6: a stalled result and its tag stay put
  a_r6_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_pair) && $stable(out_dir));

  // R7: two end markers cannot transfer back to back
  a_r7_end_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    out_edge_end && out_ready |=> !out_edge_end);

  // R2: the limited value never exceeds |R| nor L
  a_r2_tent_bound: assert property (@(posedge clk) disable iff (!rst_n)
    adv && s1_v |=> (mag16(16'(s2_lf)) <= mag16(16'($past(s1_raw))))
                 && ((mag16(16'(s2_lf)) << 1) <= 16'($past(twol))));

  // R4: with a zero strength nothing is corrected
  a_r4_zero_limit: assert property (@(posedge clk) disable iff (!rst_n)
    adv && s1_v && twol == '0 |=> s2_lf == '0);

endmodule

// File: tb/test_deblock_edge_filter.sv
module test_deblock_edge_filter;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        lim_load;
  logic [6:0]  lim_val;
  logic        in_valid;
  logic        in_ready;
  logic [31:0] in_quad;
  logic        in_dir;
  logic        out_valid;
  logic        out_ready;
  logic [15:0] out_pair;
  logic        out_dir;
  logic        out_edge_end;

  always #2 clk = ~clk;   // 250 MHz

  deblock_edge_filter i_deblock_edge_filter (
    .clk(clk), .rst_n(rst_n), .lim_load(lim_load), .lim_val(lim_val),
    .in_valid(in_valid), .in_ready(in_ready), .in_quad(in_quad), .in_dir(in_dir),
    .out_valid(out_valid), .out_ready(out_ready), .out_pair(out_pair),
    .out_dir(out_dir), .out_edge_end(out_edge_end)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // {dir, x3, x2, x1, x0, exp_n2, exp_n1}; strength L = 10 for the whole edge
  localparam logic [48:0] VEC [8] = '{
    {1'b0, 8'd50,  8'd76,  8'd50,  8'd50,  8'd66,  8'd60 },  // R2: |R| = L exactly
    {1'b1, 8'd100, 8'd120, 8'd100, 8'd100, 8'd112, 8'd108},  // R1: R = 8
    {1'b0, 8'd100, 8'd100, 8'd120, 8'd100, 8'd107, 8'd113},  // R1: R = -7
    {1'b1, 8'd100, 8'd140, 8'd100, 8'd100, 8'd135, 8'd105},  // R2: falling slope
    {1'b0, 8'd100, 8'd160, 8'd100, 8'd100, 8'd160, 8'd100},  // R2: |R| above 2L
    {1'b1, 8'd0,   8'd214, 8'd254, 8'd255, 8'd211, 8'd255},  // R3: high clamp
    {1'b0, 8'd255, 8'd41,  8'd1,   8'd0,   8'd44,  8'd0  },  // R3: low clamp
    {1'b1, 8'd100, 8'd100, 8'd103, 8'd100, 8'd101, 8'd102}   // R1: negative rounding
  };

  logic [16:0] exp_q [$];   // {dir, pair}
  int mon_cnt = 0;
  int ends_seen = 0;

  // output monitor, sampling mid-cycle
  always @(negedge clk) begin
    if (!rst_n) begin
      mon_cnt = 0;
      ends_seen = 0;
    end else if (out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R5 unexpected output", 1, 0);
      end else begin
        logic [16:0] e;
        e = exp_q.pop_front();
        chk(out_pair[7:0] == e[7:0], "R3 new x1", out_pair[7:0], e[7:0]);
        chk(out_pair[15:8] == e[15:8], "R3 new x2", out_pair[15:8], e[15:8]);
        chk(out_dir == e[16], "R8 direction tag", out_dir, e[16]);
      end
      chk(out_edge_end == (mon_cnt == 7), "R7 edge end", out_edge_end, mon_cnt == 7);
      if (out_edge_end) ends_seen++;
      mon_cnt = (mon_cnt + 1) % 8;
    end
  end

  // drive from just after a rising edge; returns just after the accepting edge
  task automatic send(input logic [31:0] q, input logic d);
    bit ok;
    in_valid = 1'b1;
    in_quad  = q;
    in_dir   = d;
    forever begin
      @(negedge clk);
      ok = in_ready;
      @(posedge clk);
      #1;
      if (ok) break;
    end
    in_valid = 1'b0;
  endtask

  task automatic load_lim(input logic [6:0] l);
    lim_val  = l;
    lim_load = 1'b1;
    @(posedge clk); #1;
    lim_load = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    lim_load = 1'b0; lim_val = '0; in_valid = 1'b0; in_quad = '0; in_dir = 1'b0;
    out_ready = 1'b1;
    rst_n = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R10 out_valid in reset", out_valid, 0);
    do_reset();
    @(negedge clk);
    chk(out_valid == 1'b0, "R10 out_valid after reset", out_valid, 0);
    chk(out_edge_end == 1'b0, "R10 edge end after reset", out_edge_end, 0);
    chk(in_ready == 1'b1, "R10 in_ready after reset", in_ready, 1);
    @(posedge clk); #1;

    // one full edge, back to back, strength loaded once (R4, R9)
    load_lim(7'd10);
    for (int i = 0; i < 8; i++) begin
      exp_q.push_back({VEC[i][48], VEC[i][15:0]});
      send(VEC[i][47:16], VEC[i][48]);
    end
    idle(6);
    chk(ends_seen == 1, "R7 one edge end after eight lines", ends_seen, 1);
    chk(exp_q.size() == 0, "R5 all lines returned", exp_q.size(), 0);

    // reset clears the strength: pass-through (R4)
    do_reset();
    exp_q.push_back({1'b0, 8'd120, 8'd100});
    send({8'd100, 8'd120, 8'd100, 8'd100}, 1'b0);
    idle(5);

    // largest strength and largest R (R1, R2): R = 128, 2L = 254 -> lf = 126
    load_lim(7'd127);
    exp_q.push_back({1'b1, 8'd129, 8'd126});
    send({8'd0, 8'd255, 8'd0, 8'd255}, 1'b1);
    idle(5);

    // latency (R5)
    load_lim(7'd10);
    exp_q.push_back({1'b0, 8'd112, 8'd108});
    send({8'd100, 8'd120, 8'd100, 8'd100}, 1'b0);
    @(negedge clk);
    chk(out_valid == 1'b0, "R5 not valid after edge 1", out_valid, 0);
    @(negedge clk);
    chk(out_valid == 1'b0, "R5 not valid after edge 2", out_valid, 0);
    @(negedge clk);
    chk(out_valid == 1'b1, "R5 valid after edge 3", out_valid, 1);
    @(posedge clk); #1;
    idle(3);

    // back-pressure with a line offered (R6)
    out_ready = 1'b0;
    exp_q.push_back({1'b1, 8'd112, 8'd108});
    exp_q.push_back({1'b0, 8'd107, 8'd113});
    exp_q.push_back({1'b1, 8'd135, 8'd105});
    exp_q.push_back({1'b0, 8'd66,  8'd60 });
    send({8'd100, 8'd120, 8'd100, 8'd100}, 1'b1);
    send({8'd100, 8'd100, 8'd120, 8'd100}, 1'b0);
    send({8'd100, 8'd140, 8'd100, 8'd100}, 1'b1);
    in_valid = 1'b1;
    in_quad  = {8'd50, 8'd76, 8'd50, 8'd50};
    in_dir   = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(in_ready == 1'b0, "R6 in_ready low while stalled", in_ready, 0);
      chk(out_valid == 1'b1, "R6 result waiting", out_valid, 1);
      chk(out_pair == {8'd112, 8'd108}, "R6 held pair", out_pair, {8'd112, 8'd108});
      chk(out_dir == 1'b1, "R6 held tag", out_dir, 1);
    end
    @(posedge clk); #1;
    out_ready = 1'b1;
    @(posedge clk); #1;     // offered line transfers on this edge
    in_valid = 1'b0;
    idle(8);
    chk(exp_q.size() == 0, "R6 every stalled line delivered", exp_q.size(), 0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog R5 actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule